// File: doc/BRIEF.md
# Input Delay Eye-Centering Trainer

This block trains one lane of a source-synchronous, single-data-rate receiver. It drives an external 64-step input delay line that can move only one step at a time, through a one-cycle step pulse and a direction bit. After a start request, it first walks the delay back to step 0. It then waits until the delay-reference calibration reports ready, and sweeps the delay upward while the transmitter sends a toggling training pattern. At each step it grades the sampled bit as stable or unstable.

The sweep finds the boundaries of a stable window (the data eye). The block then walks the delay back down to the midpoint of that window, rounded down, and raises `done`. If no step is stable it returns the delay to step 0 and raises `error` instead. A new start request restarts training from any state.

Top module: `eye_trainer`

## Requirements
- R1: After reset `tap_value` is 0, `done` and `error` are low, and no step pulse is issued until `start` is seen.
- R2: After a start, no increment pulse is issued while `ref_ready` is low. Only the decrements that return the delay to step 0 may occur.
- R3: Every cycle with `tap_ce` high moves `tap_value` by exactly one step, up when `tap_inc`=1 and down when `tap_inc`=0. `tap_value` changes in no other cycle and never leaves the range 0..63.
- R4: Each step is graded after a 4-cycle settle, a reference sample, and 16 compare cycles. The step is stable only if the sampled bit differs from the previous cycle's bit in all 16 compares. A single repeated bit makes the step unstable.
- R5: The lower eye edge is the first stable step that directly follows an unstable step during the upward sweep.
- R6: The upper eye edge is the last stable step before the next unstable step. If the sweep reaches step 63 while still stable, the upper edge is 63.
- R7: If no stable step follows an unstable step, the run of stable steps that begins at step 0 is used as the eye.
- R8: On success the delay parks at floor((lower+upper)/2). It reaches that step by decrement pulses only, issued on consecutive cycles, and then `done`=1 and `error`=0.
- R9: If no step of the 64 is stable, the delay is returned to 0, `error`=1 and `done`=0.
- R10: A start pulse in any state clears `done` and `error` on the next cycle, returns the delay to step 0, and trains again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | One-cycle request to (re)run training |
| ref_ready | input | 1 | Delay-reference calibration is complete |
| sample_bit | input | 1 | Lane bit as sampled through the delay line |
| tap_ce | output | 1 | One-cycle step command to the delay line |
| tap_inc | output | 1 | Step direction: 1 increment, 0 decrement |
| tap_value | output | 6 | Current delay step as tracked by the block |
| done | output | 1 | Training finished; delay parked at eye centre |
| error | output | 1 | Training found no stable step |

## Verification
Any wrong internal state shows at the ports as a final `tap_value` that differs from the eye midpoint the bench derives from its stable-step mask. It can also show as a mismatch between `tap_value` and the bench's own step count, rebuilt from the pulses. A bad step counter shows on the first pulse after it goes wrong. A mis-graded step or a wrong edge choice shows only when training ends, at most about 1500 cycles after the sweep begins. A wrong status flag shows on the cycle after the start pulse or at the end of the run.

// File: rtl/eye_trainer_pkg.sv
package eye_trainer_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_ZERO,
    S_WAIT_REF,
    S_MEAS_START,
    S_MEAS_WAIT,
    S_STEP,
    S_RETURN,
    S_DONE,
    S_FAIL
  } train_state_t;

  typedef enum logic [1:0] {
    P_IDLE,
    P_SETTLE,
    P_REF,
    P_CMP
  } grade_phase_t;
endpackage

// File: rtl/et_reset_sync.sv
module et_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/et_tap_tracker.sv
module et_tap_tracker #(
  parameter int TAPS  = 64,
  parameter int TAP_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_req,
  input  logic             dec_req,
  output logic [TAP_W-1:0] tap_q,
  output logic             ce_q,
  output logic             dir_q
);
  localparam logic [TAP_W-1:0] TAP_MAX = TAP_W'(TAPS - 1);

  logic [TAP_W-1:0] tap_d;
  logic             ce_d;
  logic             dir_d;

  always_comb begin
    tap_d = tap_q;
    ce_d  = 1'b0;
    dir_d = dir_q;
    if (inc_req && (tap_q != TAP_MAX)) begin
      tap_d = tap_q + 1'b1;
      ce_d  = 1'b1;
      dir_d = 1'b1;
    end else if (dec_req && (tap_q != '0)) begin
      tap_d = tap_q - 1'b1;
      ce_d  = 1'b1;
      dir_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q <= '0;
      ce_q  <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      tap_q <= tap_d;
      ce_q  <= ce_d;
      dir_q <= dir_d;
    end
  end

  a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_q && dir_q) |-> (tap_q == $past(tap_q) + 1'b1));
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_q && !dir_q) |-> ($past(tap_q) != '0 && tap_q == $past(tap_q) - 1'b1));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_q |-> $stable(tap_q));
endmodule

// File: rtl/et_stability_grader.sv
module et_stability_grader
  import eye_trainer_pkg::*;
#(
  parameter int SETTLE = 4,
  parameter int WINDOW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic bit_i,
  output logic valid_o,
  output logic stable_o
);
  localparam int CNT_MAX = (SETTLE > WINDOW) ? SETTLE : WINDOW;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE - 1);
  localparam logic [CW-1:0] WINDOW_LAST = CW'(WINDOW - 1);

  grade_phase_t phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          prev_q, prev_d;
  logic          err_q, err_d;
  logic          valid_d, stable_d;
  logic          repeat_now;

  assign repeat_now = (bit_i == prev_q);

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    prev_d   = prev_q;
    err_d    = err_q;
    valid_d  = 1'b0;
    stable_d = stable_o;
    if (start_i) begin
      phase_d = P_SETTLE;
      cnt_d   = '0;
    end else begin
      case (phase_q)
        P_SETTLE: begin
          if (cnt_q == SETTLE_LAST) phase_d = P_REF;
          else cnt_d = cnt_q + 1'b1;
        end
        P_REF: begin
          prev_d  = bit_i;
          err_d   = 1'b0;
          cnt_d   = '0;
          phase_d = P_CMP;
        end
        P_CMP: begin
          prev_d = bit_i;
          err_d  = err_q | repeat_now;
          if (cnt_q == WINDOW_LAST) begin
            valid_d  = 1'b1;
            stable_d = !(err_q | repeat_now);
            phase_d  = P_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= P_IDLE;
      cnt_q    <= '0;
      prev_q   <= 1'b0;
      err_q    <= 1'b0;
      valid_o  <= 1'b0;
      stable_o <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      prev_q   <= prev_d;
      err_q    <= err_d;
      valid_o  <= valid_d;
      stable_o <= stable_d;
    end
  end

  a_r4_verdict_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($past(phase_q) == P_CMP));
  a_r4_repeat_is_unstable: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == P_CMP && !start_i && repeat_now && cnt_q == WINDOW_LAST) |=> (valid_o && !stable_o));
endmodule

// File: rtl/eye_trainer.sv
module eye_trainer
  import eye_trainer_pkg::*;
#(
  parameter int TAPS   = 64,
  parameter int SETTLE = 4,
  parameter int WINDOW = 16,
  parameter int TAP_W  = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ref_ready,
  input  logic             sample_bit,
  output logic             tap_ce,
  output logic             tap_inc,
  output logic [TAP_W-1:0] tap_value,
  output logic             done,
  output logic             error
);
  localparam logic [TAP_W-1:0] TAP_MAX = TAP_W'(TAPS - 1);

  logic rst_ns;
  logic inc_req, dec_req;
  logic grade_start, grade_valid, grade_stable;
  logic [TAP_W-1:0] tap_q;

  train_state_t st_q, st_d;
  logic [TAP_W-1:0] e1_q, e1_d, e2_q, e2_d;
  logic [TAP_W-1:0] fb1_q, fb1_d, fb2_q, fb2_d;
  logic [TAP_W-1:0] target_q, target_d;
  logic have_q, have_d, prov_q, prov_d, seen_q, seen_d;
  logic closed_q, closed_d, hasfb_q, hasfb_d, fail_q, fail_d;

  et_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  et_tap_tracker #(.TAPS(TAPS), .TAP_W(TAP_W)) u_tap (
    .clk     (clk),
    .rst_n   (rst_ns),
    .inc_req (inc_req),
    .dec_req (dec_req),
    .tap_q   (tap_q),
    .ce_q    (tap_ce),
    .dir_q   (tap_inc)
  );

  et_stability_grader #(.SETTLE(SETTLE), .WINDOW(WINDOW)) u_grade (
    .clk      (clk),
    .rst_n    (rst_ns),
    .start_i  (grade_start),
    .bit_i    (sample_bit),
    .valid_o  (grade_valid),
    .stable_o (grade_stable)
  );

  function automatic logic [TAP_W-1:0] mid(input logic [TAP_W-1:0] a, input logic [TAP_W-1:0] b);
    logic [TAP_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[TAP_W:1];
  endfunction

  always_comb begin
    st_d        = st_q;
    e1_d        = e1_q;
    e2_d        = e2_q;
    fb1_d       = fb1_q;
    fb2_d       = fb2_q;
    target_d    = target_q;
    have_d      = have_q;
    prov_d      = prov_q;
    seen_d      = seen_q;
    closed_d    = closed_q;
    hasfb_d     = hasfb_q;
    fail_d      = fail_q;
    inc_req     = 1'b0;
    dec_req     = 1'b0;
    grade_start = 1'b0;
    if (start) begin
      st_d     = S_ZERO;
      have_d   = 1'b0;
      prov_d   = 1'b0;
      seen_d   = 1'b0;
      closed_d = 1'b0;
      hasfb_d  = 1'b0;
      fail_d   = 1'b0;
    end else begin
      case (st_q)
        S_ZERO: begin
          if (tap_q != '0) dec_req = 1'b1;
          else st_d = S_WAIT_REF;
        end
        S_WAIT_REF: begin
          if (ref_ready) st_d = S_MEAS_START;
        end
        S_MEAS_START: begin
          grade_start = 1'b1;
          st_d        = S_MEAS_WAIT;
        end
        S_MEAS_WAIT: begin
          if (grade_valid) begin
            if (grade_stable) begin
              if (!have_q) begin
                have_d = 1'b1;
                e1_d   = tap_q;
                e2_d   = tap_q;
                prov_d = !seen_q;
              end else if (!closed_q) begin
                e2_d = tap_q;
              end
            end else begin
              seen_d = 1'b1;
              if (have_q && !closed_q) begin
                if (prov_q) begin
                  fb1_d   = e1_q;
                  fb2_d   = e2_q;
                  hasfb_d = 1'b1;
                  have_d  = 1'b0;
                  prov_d  = 1'b0;
                end else begin
                  closed_d = 1'b1;
                end
              end
            end
            if (closed_d) begin
              target_d = mid(e1_d, e2_d);
              st_d     = S_RETURN;
            end else if (tap_q == TAP_MAX) begin
              st_d = S_RETURN;
              if (have_d) target_d = mid(e1_d, e2_d);
              else if (hasfb_d) target_d = mid(fb1_d, fb2_d);
              else begin
                target_d = '0;
                fail_d   = 1'b1;
              end
            end else begin
              st_d = S_STEP;
            end
          end
        end
        S_STEP: begin
          inc_req = 1'b1;
          st_d    = S_MEAS_START;
        end
        S_RETURN: begin
          if (tap_q > target_q) dec_req = 1'b1;
          else st_d = fail_q ? S_FAIL : S_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q     <= S_IDLE;
      e1_q     <= '0;
      e2_q     <= '0;
      fb1_q    <= '0;
      fb2_q    <= '0;
      target_q <= '0;
      have_q   <= 1'b0;
      prov_q   <= 1'b0;
      seen_q   <= 1'b0;
      closed_q <= 1'b0;
      hasfb_q  <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      e1_q     <= e1_d;
      e2_q     <= e2_d;
      fb1_q    <= fb1_d;
      fb2_q    <= fb2_d;
      target_q <= target_d;
      have_q   <= have_d;
      prov_q   <= prov_d;
      seen_q   <= seen_d;
      closed_q <= closed_d;
      hasfb_q  <= hasfb_d;
      fail_q   <= fail_d;
    end
  end

  assign tap_value = tap_q;
  assign done      = (st_q == S_DONE);
  assign error     = (st_q == S_FAIL);

  a_r2_no_step_unready: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q == S_WAIT_REF) |=> !tap_ce);
  a_r8_return_only_down: assert property (@(posedge clk) disable iff (!rst_ns)
    ($past(st_q) == S_RETURN && tap_ce) |-> !tap_inc);
  a_r9_fail_at_zero: assert property (@(posedge clk) disable iff (!rst_ns)
    error |-> (tap_value == '0 && !done));
  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_ns)
    start |=> (!done && !error));
  a_r6_edges_ordered: assert property (@(posedge clk) disable iff (!rst_ns)
    done |-> (e1_q <= e2_q || hasfb_q));
endmodule

// File: tb/eye_trainer_tb_top.sv
module eye_trainer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ref_ready = 1'b0;
  logic sample_bit = 1'b0;
  logic tap_ce, tap_inc, done, error;
  logic [5:0] tap_value;

  int checks = 0;
  int errors = 0;
  int model_tap = 0;
  int track_err = 0;
  int inc_pulses = 0;
  int cyc = 0;
  int slip_mode = 0;
  logic [63:0] mask = '0;

  always #10 clk = ~clk;

  eye_trainer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_ready(ref_ready),
    .sample_bit(sample_bit), .tap_ce(tap_ce), .tap_inc(tap_inc),
    .tap_value(tap_value), .done(done), .error(error)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // delay-line model and lane stimulus, updated away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
    if (rst_n && tap_ce) begin
      if (tap_inc) begin
        model_tap++;
        inc_pulses++;
      end else begin
        if (model_tap == 0) track_err++;
        model_tap--;
      end
      if (model_tap != int'(tap_value) || model_tap < 0 || model_tap > 63) track_err++;
    end
    if (model_tap >= 0 && model_tap <= 63 && mask[model_tap]) sample_bit <= ~sample_bit;
    else if (slip_mode != 0 && (cyc % 8) != 0) sample_bit <= ~sample_bit;
  end

  // expected centre from the requirement rules, with stable runs found arithmetically
  function automatic int expect_tap(input logic [63:0] m, output bit fail);
    int lo, hi;
    fail = 1'b0;
    for (int t = 1; t < 64; t++) begin
      if (m[t] && !m[t-1]) begin
        lo = t; hi = t;
        while (hi < 63 && m[hi+1]) hi++;
        return (lo + hi) / 2;
      end
    end
    if (m[0]) begin
      hi = 0;
      while (hi < 63 && m[hi+1]) hi++;
      return hi / 2;
    end
    fail = 1'b1;
    return 0;
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_case(input string req, input logic [63:0] m, input int slip);
    bit f;
    int exp_t;
    int waited;
    mask = m;
    slip_mode = slip;
    ref_ready = 1'b1;
    track_err = 0;
    exp_t = expect_tap(m, f);
    pulse_start();
    check({req, " status cleared after start (R10)"}, int'(done | error), 0);
    waited = 0;
    while (!done && !error && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    check({req, " done flag"}, int'(done), f ? 0 : 1);
    check({req, " error flag (R9)"}, int'(error), f ? 1 : 0);
    check({req, " parked tap (R8)"}, int'(tap_value), exp_t);
    check({req, " model tap matches (R3)"}, model_tap, int'(tap_value));
    check({req, " step tracking (R3)"}, track_err, 0);
  endtask

  function automatic logic [63:0] range_mask(input int lo, input int hi);
    logic [63:0] r = '0;
    for (int t = lo; t <= hi; t++) r[t] = 1'b1;
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check("R1 tap after reset", int'(tap_value), 0);
    check("R1 done/error after reset", int'(done | error), 0);
    repeat (20) @(negedge clk);
    check("R1 no pulse without start", model_tap, 0);

    run_case("R5 R6 eye 10..30", range_mask(10, 30), 0);
    run_case("R5 leading run ignored", range_mask(0, 5) | range_mask(9, 40), 0);
    run_case("R6 all stable ends at 63", '1, 0);
    run_case("R6 eye reaching 63", range_mask(50, 63), 0);
    run_case("R9 no stable tap", '0, 0);
    run_case("R7 only leading run", range_mask(0, 7), 0);
    run_case("R6 single tap 63", range_mask(63, 63), 0);
    run_case("R5 one-wide eye", range_mask(20, 20), 0);
    run_case("R4 slipping pattern", range_mask(12, 27), 1);
    run_case("R5 two eyes first wins", range_mask(4, 9) | range_mask(30, 50), 1);

    // R2 and R10: restart from a parked tap with the reference not ready
    run_case("R10 setup", range_mask(30, 40), 0);
    ref_ready = 1'b0;
    inc_pulses = 0;
    pulse_start();
    repeat (150) @(negedge clk);
    check("R2 no increments while reference not ready", inc_pulses, 0);
    check("R10 tap returned to zero", int'(tap_value), 0);
    check("R2 not done while waiting", int'(done | error), 0);
    ref_ready = 1'b1;
    repeat (300) @(negedge clk);
    // R10 restart in the middle of a sweep
    run_case("R10 restart mid sweep", range_mask(22, 44), 0);

    finish_run();
  end
endmodule